// File: doc/BRIEF.md
# Trilinear Neighbourhood Cubic Address Generator

This block turns the integer voxel coordinates of one ray sample into the eight memory addresses that fetch the sample's 2x2x2 trilinear neighbourhood. The volume is spread over eight parallel memories, and each memory holds every second voxel along each axis. For every memory the block picks a halved coordinate per axis. That coordinate is either the plain half of the sample coordinate or the half rounded up, depending on which parity the memory serves. The block then converts the halved coordinate triple into a cubic address: the index of the sub-cube times the sub-cube volume, plus the offset of the voxel inside that sub-cube.

The dataset size is given per sample as base-2 logarithms of the x and y extents, so every divide, modulo and multiply reduces to a shift or a mask. The design is a two-stage pipeline with a valid flag that travels alongside the address bundle. A four-module mode serves a layout in which data is replicated over four memory modules. In that mode only four addresses come out, on the four lower lanes, and they are chosen by the parity of z.

Top module: `trilin_cubic_addr_gen`

## Requirements
- R1: While reset is held (rst_n low at a clock edge), addr_vld_o is 0 and all eight address lanes are 0.
- R2: A sample presented with smp_vld_i high at clock edge k gives addr_vld_o high after edge k+1, with that sample's addresses. addr_vld_o is low after edge k+1 for a sample that was not valid at edge k.
- R3: For memory n (n = 0..7), the coordinate used on each axis is floor(V/2) when the axis bit of n is set, and floor(V/2) + (V mod 2) when it is clear. Bit 0 of n selects for x, bit 1 for y and bit 2 for z.
- R4: Each memory address is A = s^3*C + (x mod s) + s*(y mod s) + s^2*(z mod s), where s = 2^SUB_LG. The term C is floor(x/s) + (Px/s)*floor(y/s) + (Px*Py/s^2)*floor(z/s), and Px = 2^(dim_lgx_i-1), Py = 2^(dim_lgy_i-1) are the per-memory extents. A is taken modulo 2^ADDR_W.
- R5: dim_lgx_i and dim_lgy_i are sampled together with the coordinates, so each sample uses its own dataset size. Legal values run from SUB_LG+1 to COORD_W.
- R6: With four_mode_i low, lane n of addr_o (bits n*ADDR_W and up) carries the address of memory n.
- R7: With four_mode_i high and vox_z_i even, lanes 0..3 carry memories 0..3 and lanes 4..7 are 0.
- R8: With four_mode_i high and vox_z_i odd, lane n (n = 0..3) carries memory n+4, so memory m goes to module m mod 4. Lanes 4..7 are 0.
- R9: A cycle with smp_vld_i low leaves addr_o unchanged two edges later, whatever values the coordinate, size and mode inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld_i | input | 1 | Sample coordinates are valid this cycle |
| vox_x_i | input | COORD_W | Voxel x coordinate |
| vox_y_i | input | COORD_W | Voxel y coordinate |
| vox_z_i | input | COORD_W | Voxel z coordinate |
| dim_lgx_i | input | LG_W | log2 of the dataset x extent |
| dim_lgy_i | input | LG_W | log2 of the dataset y extent |
| four_mode_i | input | 1 | 1: four-module replicated layout, 0: eight memories |
| addr_vld_o | output | 1 | Address bundle valid |
| addr_o | output | 8*ADDR_W | Eight address lanes, lane n in bits n*ADDR_W and up |

## Verification
The bench builds the block with its defaults: COORD_W = 9, SUB_LG = 3 (sub-cubes of 512 voxels) and ADDR_W = 24. Random extents from 2^4 to 2^9 per axis reach both the case of one sub-cube per row and the full-width case, where the address's top bits are set. Odd coordinates that sit just below a multiple of 16 make the rounded-up and plain halves fall into different sub-cubes, which exercises the carry from the offset into the sub-cube index. Both parities of z in four-module mode are driven, along with idle cycles that carry garbage on the inputs.

// File: rtl/trilin_addr_pkg.sv
// Package: shared constants for the trilinear cubic address generator.
// Assumes eight interleaved memories, one per corner of a 2x2x2 neighbourhood.
package trilin_addr_pkg;
    localparam int NUM_MEM  = 8;
    localparam int QUAD_MEM = 4;
    localparam int AXIS_X   = 0;
    localparam int AXIS_Y   = 1;
    localparam int AXIS_Z   = 2;

    // Axis bit of a memory index: 1 means the plain half coordinate is used.
    function automatic bit mem_takes_plain(input int mem, input int axis);
        return ((mem >> axis) & 1) == 1;
    endfunction
endpackage

// File: rtl/trilin_coord_stage.sv
// Module: first pipeline stage. It registers, per axis, the rounded-up half
// (V>>1)+V[0] and the plain half V>>1 of a sample, together with the dataset
// size, the mode and the z parity. Assumes the coordinates keep the whole
// neighbourhood inside the dataset (V <= extent-2).
module trilin_coord_stage #(
    parameter int COORD_W = 9,
    parameter int LG_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vld_i,
    input  logic [COORD_W-1:0] vx_i,
    input  logic [COORD_W-1:0] vy_i,
    input  logic [COORD_W-1:0] vz_i,
    input  logic [LG_W-1:0]    lgx_i,
    input  logic [LG_W-1:0]    lgy_i,
    input  logic               quad_i,
    output logic               vld_o,
    output logic [COORD_W-1:0] upx_o,
    output logic [COORD_W-1:0] lox_o,
    output logic [COORD_W-1:0] upy_o,
    output logic [COORD_W-1:0] loy_o,
    output logic [COORD_W-1:0] upz_o,
    output logic [COORD_W-1:0] loz_o,
    output logic [LG_W-1:0]    lgx_o,
    output logic [LG_W-1:0]    lgy_o,
    output logic               quad_o,
    output logic               zodd_o
);
    logic [COORD_W-1:0] hx, hy, hz;

    // Plain halves of the incoming coordinates.
    always_comb begin
        hx = vx_i >> 1;
        hy = vy_i >> 1;
        hz = vz_i >> 1;
    end

    // Valid flag: cleared by reset, follows the input every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= vld_i;
    end

    // Data registers: loaded only with a valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upx_o  <= '0;
            lox_o  <= '0;
            upy_o  <= '0;
            loy_o  <= '0;
            upz_o  <= '0;
            loz_o  <= '0;
            lgx_o  <= '0;
            lgy_o  <= '0;
            quad_o <= 1'b0;
            zodd_o <= 1'b0;
        end else if (vld_i) begin
            upx_o  <= hx + COORD_W'(vx_i[0]);
            lox_o  <= hx;
            upy_o  <= hy + COORD_W'(vy_i[0]);
            loy_o  <= hy;
            upz_o  <= hz + COORD_W'(vz_i[0]);
            loz_o  <= hz;
            lgx_o  <= lgx_i;
            lgy_o  <= lgy_i;
            quad_o <= quad_i;
            zodd_o <= vz_i[0];
        end
    end

    // R3: the rounded-up half never differs from the plain half by more than one.
    assert_half_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> ((upx_o - lox_o) <= COORD_W'(1)) &&
                  ((upy_o - loy_o) <= COORD_W'(1)) &&
                  ((upz_o - loz_o) <= COORD_W'(1)));
endmodule

// File: rtl/trilin_cubic_map.sv
// Module: combinational cubic address of one halved coordinate triple.
// The sub-cube index is laid out with the per-memory extents 2^(lg-1),
// all products are shifts. Assumes lg >= SUB_LG+1 on both axes.
module trilin_cubic_map #(
    parameter int COORD_W = 9,
    parameter int LG_W    = 4,
    parameter int SUB_LG  = 3,
    parameter int ADDR_W  = 24
) (
    input  logic [COORD_W-1:0] x_i,
    input  logic [COORD_W-1:0] y_i,
    input  logic [COORD_W-1:0] z_i,
    input  logic [LG_W-1:0]    lgx_i,
    input  logic [LG_W-1:0]    lgy_i,
    output logic [ADDR_W-1:0]  addr_o
);
    localparam int SUB_MASK = (1 << SUB_LG) - 1;

    logic [ADDR_W-1:0] cx, cy, cz, ox, oy, oz, cube_idx, offs;
    int                sh_y, sh_z;

    // Split every axis into its sub-cube number and in-cube offset.
    always_comb begin
        cx = ADDR_W'(x_i >> SUB_LG);
        cy = ADDR_W'(y_i >> SUB_LG);
        cz = ADDR_W'(z_i >> SUB_LG);
        ox = ADDR_W'(x_i & COORD_W'(SUB_MASK));
        oy = ADDR_W'(y_i & COORD_W'(SUB_MASK));
        oz = ADDR_W'(z_i & COORD_W'(SUB_MASK));
    end

    // Row and slice strides of the sub-cube grid, as shift distances.
    always_comb begin
        sh_y = int'(lgx_i) - 1 - SUB_LG;
        sh_z = int'(lgx_i) + int'(lgy_i) - 2 - 2 * SUB_LG;
    end

    // Sub-cube index, in-cube offset and final address.
    always_comb begin
        cube_idx = cx + (cy << sh_y) + (cz << sh_z);
        offs     = ox + (oy << SUB_LG) + (oz << (2 * SUB_LG));
        addr_o   = (cube_idx << (3 * SUB_LG)) + offs;
    end
endmodule

// File: rtl/trilin_cubic_addr_gen.sv
// Module: top of the trilinear neighbourhood address generator. Stage one
// halves the coordinates, eight generated lanes form one cubic address per
// memory, stage two registers them, remapped for the four-module layout.
// Latency is two clocks. Assumes power-of-two extents and sub-cube size.
module trilin_cubic_addr_gen
    import trilin_addr_pkg::*;
#(
    parameter int COORD_W = 9,
    parameter int SUB_LG  = 3,
    parameter int LG_W    = $clog2(COORD_W + 1),
    parameter int ADDR_W  = 3 * (COORD_W - 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      smp_vld_i,
    input  logic [COORD_W-1:0]        vox_x_i,
    input  logic [COORD_W-1:0]        vox_y_i,
    input  logic [COORD_W-1:0]        vox_z_i,
    input  logic [LG_W-1:0]           dim_lgx_i,
    input  logic [LG_W-1:0]           dim_lgy_i,
    input  logic                      four_mode_i,
    output logic                      addr_vld_o,
    output logic [NUM_MEM*ADDR_W-1:0] addr_o
);
    logic               s1_vld, s1_quad, s1_zodd;
    logic [COORD_W-1:0] upx, lox, upy, loy, upz, loz;
    logic [LG_W-1:0]    s1_lgx, s1_lgy;
    logic [ADDR_W-1:0]  lane_addr [NUM_MEM];
    logic [ADDR_W-1:0]  next_addr [NUM_MEM];
    logic [ADDR_W-1:0]  s2_addr   [NUM_MEM];
    logic               s2_quad;
    logic [1:0]         since_rst;

    trilin_coord_stage #(.COORD_W(COORD_W), .LG_W(LG_W)) u_stage1 (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (smp_vld_i),
        .vx_i  (vox_x_i),
        .vy_i  (vox_y_i),
        .vz_i  (vox_z_i),
        .lgx_i (dim_lgx_i),
        .lgy_i (dim_lgy_i),
        .quad_i(four_mode_i),
        .vld_o (s1_vld),
        .upx_o (upx),
        .lox_o (lox),
        .upy_o (upy),
        .loy_o (loy),
        .upz_o (upz),
        .loz_o (loz),
        .lgx_o (s1_lgx),
        .lgy_o (s1_lgy),
        .quad_o(s1_quad),
        .zodd_o(s1_zodd)
    );

    // One coordinate select and cubic map per memory, then the lane remap.
    for (genvar m = 0; m < NUM_MEM; m++) begin : g_mem
        localparam bit PX = mem_takes_plain(m, AXIS_X);
        localparam bit PY = mem_takes_plain(m, AXIS_Y);
        localparam bit PZ = mem_takes_plain(m, AXIS_Z);

        trilin_cubic_map #(
            .COORD_W(COORD_W), .LG_W(LG_W), .SUB_LG(SUB_LG), .ADDR_W(ADDR_W)
        ) u_map (
            .x_i   (PX ? lox : upx),
            .y_i   (PY ? loy : upy),
            .z_i   (PZ ? loz : upz),
            .lgx_i (s1_lgx),
            .lgy_i (s1_lgy),
            .addr_o(lane_addr[m])
        );

        if (m < QUAD_MEM) begin : g_low
            // Lower lane: own memory, or its odd-z partner in four-module mode.
            always_comb next_addr[m] = (s1_quad && s1_zodd) ? lane_addr[m + QUAD_MEM]
                                                            : lane_addr[m];
        end else begin : g_high
            // Upper lane: silent in four-module mode.
            always_comb next_addr[m] = s1_quad ? '0 : lane_addr[m];
        end

        assign addr_o[m*ADDR_W +: ADDR_W] = s2_addr[m];
    end

    // Output stage: valid every cycle, addresses loaded only with valid data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_vld_o <= 1'b0;
            s2_quad    <= 1'b0;
            for (int m = 0; m < NUM_MEM; m++) s2_addr[m] <= '0;
        end else begin
            addr_vld_o <= s1_vld;
            if (s1_vld) begin
                s2_quad <= s1_quad;
                for (int m = 0; m < NUM_MEM; m++) s2_addr[m] <= next_addr[m];
            end
        end
    end

    // Cycles since reset, saturating: guards the two-deep latency check.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst <= 2'd0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    // R2: the valid flag emerges exactly two edges after the sample.
    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (addr_vld_o == $past(smp_vld_i, 2)));

    // R9: an idle stage leaves the address bundle unchanged.
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(s1_vld) |-> $stable(addr_o));

    // R7: upper lanes stay silent while a four-module bundle is shown.
    assert_upper_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld_o && s2_quad) |-> (addr_o[NUM_MEM*ADDR_W-1:QUAD_MEM*ADDR_W] == '0));

    // R4: rounding up on every axis never gives a lower cubic address.
    assert_corner_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld_o && !s2_quad) |-> (s2_addr[0] >= s2_addr[NUM_MEM-1]));
endmodule

// File: tb/trilin_cubic_addr_gen_bench.sv
module trilin_cubic_addr_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CW  = 9;
    localparam int SL  = 3;
    localparam int LW  = 4;
    localparam int AW  = 24;
    localparam int SUB = 1 << SL;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              vld = 1'b0;
    logic [CW-1:0]     vx = '0, vy = '0, vz = '0;
    logic [LW-1:0]     lgx = LW'(9), lgy = LW'(9);
    logic              quad = 1'b0;
    logic              vld_o;
    logic [8*AW-1:0]   addr_o;

    int errs = 0;
    int checks = 0;
    longint last_exp [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    trilin_cubic_addr_gen #(.COORD_W(CW), .SUB_LG(SL), .LG_W(LW), .ADDR_W(AW)) u_trilin_cubic_addr_gen (
        .clk(clk), .rst_n(rst_n), .smp_vld_i(vld),
        .vox_x_i(vx), .vox_y_i(vy), .vox_z_i(vz),
        .dim_lgx_i(lgx), .dim_lgy_i(lgy), .four_mode_i(quad),
        .addr_vld_o(vld_o), .addr_o(addr_o)
    );

    // Half coordinate for one axis: plain or rounded up.
    function automatic int half(input int v, input bit plain);
        return plain ? v / 2 : v / 2 + v % 2;
    endfunction

    // Reference cubic address of memory m (R3, R4).
    function automatic longint ref_addr(input int ix, iy, iz, ilx, ily, m);
        int x = half(ix, (m & 1) != 0);
        int y = half(iy, (m & 2) != 0);
        int z = half(iz, (m & 4) != 0);
        longint px = longint'(1) << (ilx - 1);
        longint py = longint'(1) << (ily - 1);
        longint cube = x / SUB + (px / SUB) * (y / SUB) + (px * py / (SUB * SUB)) * (z / SUB);
        longint a = cube * SUB * SUB * SUB + x % SUB + SUB * (y % SUB) + SUB * SUB * (z % SUB);
        return a % (longint'(1) << AW);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare all lanes with the remembered expectation.
    task automatic check_lanes(input string req);
        for (int m = 0; m < 8; m++)
            check(req, longint'(addr_o[m*AW +: AW]), last_exp[m]);
    endtask

    // Present one sample, follow it through the pipe and check the result.
    task automatic send(input int ix, iy, iz, ilx, ily, input bit q);
        vx = CW'(ix); vy = CW'(iy); vz = CW'(iz);
        lgx = LW'(ilx); lgy = LW'(ily); quad = q; vld = 1'b1;
        for (int m = 0; m < 8; m++) begin
            if (!q)                                  last_exp[m] = ref_addr(ix, iy, iz, ilx, ily, m);       // R6
            else if (m >= 4)                         last_exp[m] = 0;                                       // R7 R8
            else if (iz % 2 == 1)                    last_exp[m] = ref_addr(ix, iy, iz, ilx, ily, m + 4);   // R8
            else                                     last_exp[m] = ref_addr(ix, iy, iz, ilx, ily, m);       // R7
        end
        @(negedge clk);
        vld = 1'b0;
        check("R2 not early", longint'(vld_o), 0);
        @(negedge clk);
        check("R2 valid", longint'(vld_o), 1);
        check_lanes(q ? (iz % 2 == 1 ? "R8" : "R7") : "R6 R3 R4 R5");
    endtask

    // Idle cycle with garbage inputs: output must stay (R9).
    task automatic idle_garbage();
        vx = CW'($urandom); vy = CW'($urandom); vz = CW'($urandom);
        lgx = LW'($urandom); quad = ~quad; vld = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R9 valid low", longint'(vld_o), 0);
        check_lanes("R9");
        lgx = LW'(9); lgy = LW'(9);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        vld = 1'b1; vx = CW'(33); vy = CW'(5); vz = CW'(7);
        repeat (3) @(negedge clk);
        check("R1 valid", longint'(vld_o), 0);
        for (int m = 0; m < 8; m++) last_exp[m] = 0;
        check_lanes("R1");
        vld = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners.
        send(0, 0, 0, 9, 9, 1'b0);
        send(1, 1, 1, 9, 9, 1'b0);        // lane0 = 73, lane7 = 0
        send(15, 0, 0, 9, 9, 1'b0);       // crosses into next sub-cube on x
        send(15, 31, 47, 5, 6, 1'b0);
        send(14, 14, 14, 4, 4, 1'b0);     // smallest extents
        send(509, 510, 507, 9, 9, 1'b0);  // high bits of the address
        send(3, 5, 6, 9, 9, 1'b1);        // four-module, z even
        send(3, 5, 7, 9, 9, 1'b1);        // four-module, z odd
        idle_garbage();
        send(77, 200, 301, 9, 9, 1'b0);
        idle_garbage();

        // Random samples within legal ranges.
        for (int i = 0; i < 300; i++) begin
            int ilx = 4 + int'($urandom % 6);
            int ily = 4 + int'($urandom % 6);
            int ilz = 4 + int'($urandom % 6);
            int ix = int'($urandom % ((1 << ilx) - 1));
            int iy = int'($urandom % ((1 << ily) - 1));
            int iz = int'($urandom % ((1 << ilz) - 1));
            send(ix, iy, iz, ilx, ily, ($urandom % 3) == 0);
            if (i % 25 == 0) idle_garbage();
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule